// File: doc/BRIEF.md
# Stuck-Data Auto-Mute Controller for Serial Stereo Audio

This block sits beside a serial stereo audio receiver and decides when the two output channels should be silenced. It samples the serial data line on each rising edge of the bit clock. It groups those samples into frames that are delimited by the frame (left/right) clock. When every sampled bit stays at one level for a long unbroken run of frames, it flags both channels as muted. The level can be all zeros or all ones. The samples themselves are MSB-first two's complement words, and the frame clock level tells which channel a bit belongs to. The block only needs to know whether the line ever moves, so it never assembles the bits into words.

All inputs are asynchronous to the system clock. Each passes through a two-flop synchroniser, and the clock edges are found by comparing each synchronised clock with its value one system cycle earlier. The auto-mute decision is gated by an active-low enable. Each channel's output is then ORed with that channel's own active-low manual mute request. The outputs are registered.

Top module: `audio_stuck_mute`

## Requirements
- R1: After synchronous reset, with both mute requests released (high), both mute outputs read 0. No frame is counted before the first frame boundary after reset.
- R2: Driving `mute_l_req_n` low sets `mute_l_o` to 1 within 6 system clocks, whatever the data. `mute_r_o` is not affected.
- R3: Driving `mute_r_req_n` low sets `mute_r_o` to 1 within 6 system clocks, whatever the data. `mute_l_o` is not affected.
- R4: A frame ends on each falling edge of `frame_clk_i`. A frame counts as clean when every bit sampled in it equals the held level. With auto-mute enabled (`amute_en_n` low), both outputs go to 1 within 6 system clocks of the end of the 8192nd consecutive clean frame at level 0.
- R5: After only 8191 consecutive clean frames, the outputs stay 0.
- R6: A held level of 1 qualifies exactly like a held level of 0. It takes 8192 clean frames to mute.
- R7: A sampled bit that differs from the held level releases auto-mute within 6 system clocks and restarts the run at zero. The differing bit becomes the new held level, and the frame that contains it does not count.
- R8: The run count saturates at 8192. Further clean frames keep both outputs muted, and the count does not wrap.
- R9: While `amute_en_n` is high, the auto-mute condition does not reach the outputs, but the run keeps being tracked. Driving `amute_en_n` low again shows an existing stuck condition at once, within 6 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk_i | input | 1 | Serial bit clock; data is sampled on its rising edge |
| frame_clk_i | input | 1 | Frame (left/right) clock; a falling edge ends a frame |
| sdata_i | input | 1 | Serial audio data line |
| amute_en_n | input | 1 | Active-low enable for the automatic mute |
| mute_l_req_n | input | 1 | Active-low manual mute request, left channel |
| mute_r_req_n | input | 1 | Active-low manual mute request, right channel |
| mute_l_o | output | 1 | Left channel mute flag |
| mute_r_o | output | 1 | Right channel mute flag |

## Verification
A run counter that drifts by even one frame shows up at the ports as a mute that is one frame early or one frame late. So the 8191-frame and 8192-frame boundaries are checked at level 0, and the level-1 run is checked again at both boundaries after a disturbance. A held-level register that fails to follow a disturbing bit would keep the level-1 run from ever muting. A count that is not cleared on a mismatch would mute far too soon. Any error in the release path shows up within a few system clocks of the disturbing bit, before that frame ends.

// File: rtl/asm_pkg.sv
package asm_pkg;

    // Bit positions inside the synchronised input vector
    localparam int SYN_BCLK  = 0;
    localparam int SYN_FCLK  = 1;
    localparam int SYN_DATA  = 2;
    localparam int SYN_EN_N  = 3;
    localparam int SYN_LRQ_N = 4;
    localparam int SYN_RRQ_N = 5;
    localparam int SYN_W     = 6;

    // Reset image of the synchroniser: clocks idle, requests released
    localparam logic [SYN_W-1:0] SYN_INIT = 6'b111010;

    typedef struct packed {
        logic left;
        logic right;
    } mute_pair_t;

endpackage

// File: rtl/asm_sync.sv
module asm_sync #(
    parameter int               WIDTH  = 1,
    parameter int               STAGES = 2,
    parameter logic [WIDTH-1:0] INIT   = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (rst) stg_q[i] <= INIT;
            else     stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/asm_edge.sv
module asm_edge (
    input  logic clk,
    input  logic rst,
    input  logic bclk_s,
    input  logic fclk_s,
    output logic bit_stb,
    output logic frame_end
);

    typedef struct packed {
        logic bclk;
        logic fclk;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.bclk = bclk_s;
        prev_d.fclk = fclk_s;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '{bclk: 1'b0, fclk: 1'b1};
        else     prev_q <= prev_d;
    end

    assign bit_stb   = bclk_s & ~prev_q.bclk;
    assign frame_end = ~fclk_s & prev_q.fclk;

    // R4: a frame boundary is a single-cycle pulse
    a_r4_frame_pulse: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !frame_end);

endmodule

// File: rtl/asm_run.sv
module asm_run #(
    parameter int RUN_LEN = 8192,
    localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_stb,
    input  logic             bit_val,
    input  logic             frame_end,
    output logic             stuck_o,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lvl;
        logic             lvl_ok;
        logic             clean;
        logic             stuck;
    } run_t;

    run_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // close the frame first: the bit in this cycle belongs to the next one
        if (frame_end) begin
            if (s_q.clean && s_q.lvl_ok && s_q.cnt != CNT_MAX) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
            s_d.clean = 1'b1;
        end
        if (bit_stb) begin
            if (!s_q.lvl_ok) begin
                s_d.lvl    = bit_val;
                s_d.lvl_ok = 1'b1;
            end else if (bit_val != s_q.lvl) begin
                s_d.lvl   = bit_val;
                s_d.cnt   = '0;
                s_d.clean = 1'b0;
            end
        end
        s_d.stuck = (s_d.cnt == CNT_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign stuck_o = s_q.stuck;
    assign count_o = s_q.cnt;

    // R8: the run count never passes its limit
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        s_q.cnt <= CNT_MAX);

    // R7: a differing bit clears the run and the stuck flag next cycle
    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && s_q.lvl_ok && bit_val != s_q.lvl) |=> (s_q.cnt == '0 && !s_q.stuck));

    // R8: without a disturbing bit the stuck flag holds
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (s_q.stuck && !(bit_stb && bit_val != s_q.lvl)) |=> s_q.stuck);

    // R4: the count only moves by one per frame boundary
    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        (!frame_end && !bit_stb) |=> $stable(s_q.cnt));

endmodule

// File: rtl/audio_stuck_mute.sv
module audio_stuck_mute #(
    parameter int RUN_LEN     = 8192,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_clk_i,
    input  logic frame_clk_i,
    input  logic sdata_i,
    input  logic amute_en_n,
    input  logic mute_l_req_n,
    input  logic mute_r_req_n,
    output logic mute_l_o,
    output logic mute_r_o
);

    import asm_pkg::*;

    localparam int CNT_W = $clog2(RUN_LEN + 1);

    logic [SYN_W-1:0] raw_in, syn;
    logic             bit_stb, frame_end, stuck;
    logic [CNT_W-1:0] run_cnt;
    mute_pair_t       out_d, out_q;

    always_comb begin
        raw_in            = '0;
        raw_in[SYN_BCLK]  = bit_clk_i;
        raw_in[SYN_FCLK]  = frame_clk_i;
        raw_in[SYN_DATA]  = sdata_i;
        raw_in[SYN_EN_N]  = amute_en_n;
        raw_in[SYN_LRQ_N] = mute_l_req_n;
        raw_in[SYN_RRQ_N] = mute_r_req_n;
    end

    asm_sync #(
        .WIDTH  (SYN_W),
        .STAGES (SYNC_STAGES),
        .INIT   (SYN_INIT)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .dout (syn)
    );

    asm_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .bclk_s    (syn[SYN_BCLK]),
        .fclk_s    (syn[SYN_FCLK]),
        .bit_stb   (bit_stb),
        .frame_end (frame_end)
    );

    asm_run #(
        .RUN_LEN (RUN_LEN)
    ) u_run (
        .clk       (clk),
        .rst       (rst),
        .bit_stb   (bit_stb),
        .bit_val   (syn[SYN_DATA]),
        .frame_end (frame_end),
        .stuck_o   (stuck),
        .count_o   (run_cnt)
    );

    always_comb begin
        logic auto_m;
        auto_m      = stuck & ~syn[SYN_EN_N];
        out_d.left  = auto_m | ~syn[SYN_LRQ_N];
        out_d.right = auto_m | ~syn[SYN_RRQ_N];
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign mute_l_o = out_q.left;
    assign mute_r_o = out_q.right;

    // R2: a left request forces the left output
    a_r2_left_req: assert property (@(posedge clk) disable iff (rst)
        !syn[SYN_LRQ_N] |=> mute_l_o);

    // R3: a right request forces the right output
    a_r3_right_req: assert property (@(posedge clk) disable iff (rst)
        !syn[SYN_RRQ_N] |=> mute_r_o);

    // R9: with auto-mute disabled and no request the left output stays clear
    a_r9_gate_left: assert property (@(posedge clk) disable iff (rst)
        (syn[SYN_EN_N] && syn[SYN_LRQ_N]) |=> !mute_l_o);

    // R4: an enabled stuck condition mutes both channels together
    a_r4_both: assert property (@(posedge clk) disable iff (rst)
        (stuck && !syn[SYN_EN_N]) |=> (mute_l_o && mute_r_o));

    // R8: the run count seen here stays in range
    a_r8_cnt_range: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= CNT_W'(RUN_LEN));

endmodule

// File: tb/audio_stuck_mute_bench.sv
module audio_stuck_mute_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;
    localparam int RUN        = 8192;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bclk = 1'b0, fclk = 1'b1, sdin = 1'b0;
    logic en_n = 1'b0, lrq_n = 1'b1, rrq_n = 1'b1;
    logic mute_l, mute_r;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_stuck_mute u_audio_stuck_mute (
        .clk          (clk),
        .rst          (rst),
        .bit_clk_i    (bclk),
        .frame_clk_i  (fclk),
        .sdata_i      (sdin),
        .amute_en_n   (en_n),
        .mute_l_req_n (lrq_n),
        .mute_r_req_n (rrq_n),
        .mute_l_o     (mute_l),
        .mute_r_o     (mute_r)
    );

    // {en_n, lrq_n, rrq_n, expect_l, expect_r}, no stuck condition present
    localparam logic [4:0] VEC [8] = '{
        5'b0_11_00, 5'b0_01_10, 5'b0_10_01, 5'b0_00_11,
        5'b1_11_00, 5'b1_01_10, 5'b1_10_01, 5'b0_11_00
    };

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    // one frame: left bit then right bit, both at level b; starts with a falling frame edge
    task automatic frame(input logic b);
        fclk = 1'b0; sdin = b; bclk = 1'b0;
        repeat (2) @(negedge clk);
        bclk = 1'b1;
        repeat (2) @(negedge clk);
        bclk = 1'b0; fclk = 1'b1;
        repeat (2) @(negedge clk);
        bclk = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        settle();
        // R1: reset state
        chk("R1 reset outputs", {mute_l, mute_r}, 2'b00);

        // R2 R3 R9: manual request table
        foreach (VEC[i]) begin
            en_n  = VEC[i][4];
            lrq_n = VEC[i][3];
            rrq_n = VEC[i][2];
            settle();
            chk($sformatf("R2/R3 table row %0d", i), {mute_l, mute_r}, VEC[i][1:0]);
        end

        // R4 R5: static zero run; first frame boundary after reset is not counted
        for (int k = 0; k < RUN; k++) frame(1'b0);
        chk("R5 zero run 8191 frames", {mute_l, mute_r}, 2'b00);
        frame(1'b0);
        chk("R4 zero run 8192 frames", {mute_l, mute_r}, 2'b11);

        // R8: saturation keeps mute
        for (int k = 0; k < 5; k++) frame(1'b0);
        chk("R8 saturated hold", {mute_l, mute_r}, 2'b11);

        // R9: disabling hides auto-mute, re-enabling shows it
        en_n = 1'b1;
        frame(1'b0);
        chk("R9 disabled hides mute", {mute_l, mute_r}, 2'b00);
        lrq_n = 1'b0;
        settle();
        chk("R2 request while disabled", {mute_l, mute_r}, 2'b10);
        lrq_n = 1'b1;
        en_n  = 1'b0;
        settle();
        chk("R9 re-enable shows mute", {mute_l, mute_r}, 2'b11);

        // R7: a disturbing frame of ones releases mute during that frame
        frame(1'b1);
        chk("R7 toggle releases", {mute_l, mute_r}, 2'b00);

        // R6 R7: run of ones restarts from zero; disturbed frame not counted
        for (int k = 0; k < RUN; k++) frame(1'b1);
        chk("R7 restart, ones 8191 frames", {mute_l, mute_r}, 2'b00);
        frame(1'b1);
        chk("R6 ones 8192 frames", {mute_l, mute_r}, 2'b11);

        // R3: right request while auto-muted is harmless
        rrq_n = 1'b0;
        settle();
        chk("R3 request during mute", {mute_l, mute_r}, 2'b11);
        rrq_n = 1'b1;

        // R1: reset clears the stuck condition
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle();
        chk("R1 reset clears mute", {mute_l, mute_r}, 2'b00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule